// File: doc/BRIEF.md
# Calendar Clock Register File

This block keeps wall-clock time and date for a host that reaches it through a byte-wide register port. The fields are seconds, minutes, hours (24-hour only), day of week, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick` advances the time by one second and carries through the larger units. A separate oscillator tick drives a rate divider. The divider raises a periodic interrupt flag at a rate the host selects.

Two control registers set the oscillator divider, the interrupt rate, the enable for the periodic interrupt, the field encoding (BCD or plain binary) and a freeze bit that stops the time from advancing. A flag register reports pending interrupts and clears itself when read. A validity register always reads as valid. The host reads any location by address, and the data returns one cycle later on `rdata`. A status bit marks an update in progress. The host cannot write this bit, and it inverts on every read of its register.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the time is 00:00:00, weekday 1, day 1, month 1, year 0. Register A (0x0A) holds 0x26, which is divider 3'b010 in bits 6:4, rate 4'd6 in bits 3:0 and bit 7 clear. Register B (0x0B) holds 0x42 with bit 2 copied from `strap_binary`.
- R2: The time fields are at these addresses: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day 0x07, month 0x08 and year 0x09. A host write there loads the field at once. Addresses with no register read as 0x00, and `rdata` appears on the cycle after `rd_en`.
- R3: Register B bit 2 sets the encoding of the time fields on both read and write. When it is 0 the fields are packed BCD. When it is 1 they are plain binary, and changing the bit re-encodes the stored value on the next read.
- R4: Each `sec_tick` advances the time by one second. Seconds carry into minutes, minutes into hours and hours into the day. The day wraps after the correct month length, and February has 29 days when the year is divisible by 4. The month wraps 12 to 1, the year wraps 99 to 0, and the weekday steps 7 to 1 at each new day.
- R5: While register B bit 7 (freeze) is 1, `sec_tick` has no effect on any time field.
- R6: Register A bit 7 (update in progress) cannot be written. A write to register A replaces bits 6:0 and keeps bit 7.
- R7: Every read of register A inverts bit 7, and the read returns the inverted value.
- R8: When the rate field r (register A bits 3:0) is nonzero, a periodic event occurs on every 2^(r-1)-th oscillator tick, counted from reset or from the last write of register A. The event sets register C bit 6. If register B bit 6 (periodic enable) is set, the event also sets register C bit 7 and drives `irq` high.
- R9: A read of register C (0x0C) returns the flags and then clears both of them, which drops `irq`. Writes to register C have no effect.
- R10: A divider value of 3'b110 or 3'b111 stops the clock. While either is selected, neither oscillator ticks nor second ticks are counted.
- R11: Register D (0x0D) always reads 0x80, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_binary | input | 1 | Reset value of the binary-encoding bit |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest case to reach is a full cascade of carries from seconds to year, above all the February boundary in leap and common years. Stepping there one second at a time would take far too long. The bench instead loads the fields to one second before midnight on the last day of a month and then sends a single tick. The divider and the periodic-rate counter are reached the same way. The bench writes register A, which restarts the count from zero, so the tick on which the flag rises can be predicted exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W_DEF = 8;

  localparam logic [7:0] A_SEC  = 8'h00;
  localparam logic [7:0] A_MIN  = 8'h02;
  localparam logic [7:0] A_HR   = 8'h04;
  localparam logic [7:0] A_WDAY = 8'h06;
  localparam logic [7:0] A_MDAY = 8'h07;
  localparam logic [7:0] A_MON  = 8'h08;
  localparam logic [7:0] A_YR   = 8'h09;
  localparam logic [7:0] A_CTLA = 8'h0A;
  localparam logic [7:0] A_CTLB = 8'h0B;
  localparam logic [7:0] A_FLAG = 8'h0C;
  localparam logic [7:0] A_VALID = 8'h0D;

  localparam logic [2:0] DIV_32K   = 3'b010;
  localparam logic [3:0] RATE_1K   = 4'd6;

  typedef enum logic [2:0] {
    FLD_SEC, FLD_MIN, FLD_HR, FLD_WDAY, FLD_MDAY, FLD_MON, FLD_YR
  } field_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'b0, v[7:4]} * 8'd10) + {4'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                     return is_leap(yr) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

  function automatic logic stop_code(input logic [2:0] dv);
    return (dv == 3'b110) || (dv == 3'b111);
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  field_e     wr_field,
  input  logic [7:0] wr_val,
  output rtc_time_t  tm
);

  rtc_time_t nxt;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;
  logic [7:0] month_len;

  assign month_len = days_in_month(tm.mon, tm.yr);
  assign sec_wrap  = (tm.sec  >= 8'd59);
  assign min_wrap  = (tm.min  >= 8'd59);
  assign hr_wrap   = (tm.hr   >= 8'd23);
  assign day_wrap  = (tm.mday >= month_len);
  assign mon_wrap  = (tm.mon  >= 8'd12);

  always_comb begin
    nxt = tm;
    if (!sec_wrap) begin
      nxt.sec = tm.sec + 8'd1;
    end else begin
      nxt.sec = 8'd0;
      if (!min_wrap) begin
        nxt.min = tm.min + 8'd1;
      end else begin
        nxt.min = 8'd0;
        if (!hr_wrap) begin
          nxt.hr = tm.hr + 8'd1;
        end else begin
          nxt.hr   = 8'd0;
          nxt.wday = (tm.wday >= 8'd7) ? 8'd1 : tm.wday + 8'd1;
          if (!day_wrap) begin
            nxt.mday = tm.mday + 8'd1;
          end else begin
            nxt.mday = 8'd1;
            if (!mon_wrap) begin
              nxt.mon = tm.mon + 8'd1;
            end else begin
              nxt.mon = 8'd1;
              nxt.yr  = (tm.yr >= 8'd99) ? 8'd0 : tm.yr + 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm <= '{sec: 8'd0, min: 8'd0, hr: 8'd0, wday: 8'd1,
              mday: 8'd1, mon: 8'd1, yr: 8'd0};
    end else if (wr_en) begin
      case (wr_field)
        FLD_SEC:  tm.sec  <= wr_val;
        FLD_MIN:  tm.min  <= wr_val;
        FLD_HR:   tm.hr   <= wr_val;
        FLD_WDAY: tm.wday <= wr_val;
        FLD_MDAY: tm.mday <= wr_val;
        FLD_MON:  tm.mon  <= wr_val;
        default:  tm.yr   <= wr_val;
      endcase
    end else if (adv) begin
      tm <= nxt;
    end
  end

  assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && tm.sec < 8'd59) |=> (tm.sec == $past(tm.sec) + 8'd1));

  assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && sec_wrap && min_wrap && hr_wrap && day_wrap) |=> (tm.mday == 8'd1));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> $stable(tm));

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int CNT_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              evt
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  mask;
  logic [RATE_W-1:0] shamt;
  logic              rate_on;

  assign rate_on = (rate != '0);
  assign shamt   = rate - RATE_W'(1);
  assign mask    = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign evt     = osc_tick && run && rate_on && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (osc_tick && run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assert_no_evt_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !evt);

  assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));

  assert_no_evt_rate0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |-> !evt);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_binary,
  input  logic              sec_tick,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam int RATE_W = 4;

  rtc_time_t  tm;
  logic       uip;
  logic [6:0] ctla;
  logic [7:0] ctlb;
  logic       pf, irqf;

  logic [7:0] a8;
  logic       hit_time;
  field_e     fsel;
  logic       wr_time, wr_a, wr_b, rd_a, rd_c;
  logic       run, freeze, pie, bin_mode;
  logic       adv, pevt;
  logic [7:0] wr_val;

  assign a8 = 8'(addr);

  always_comb begin
    hit_time = 1'b1;
    fsel     = FLD_SEC;
    if (ADDR_W > 8 && (addr >> 8) != '0) hit_time = 1'b0;
    else begin
      case (a8)
        A_SEC:   fsel = FLD_SEC;
        A_MIN:   fsel = FLD_MIN;
        A_HR:    fsel = FLD_HR;
        A_WDAY:  fsel = FLD_WDAY;
        A_MDAY:  fsel = FLD_MDAY;
        A_MON:   fsel = FLD_MON;
        A_YR:    fsel = FLD_YR;
        default: hit_time = 1'b0;
      endcase
    end
  end

  assign freeze   = ctlb[7];
  assign pie      = ctlb[6];
  assign bin_mode = ctlb[2];
  assign run      = !stop_code(ctla[6:4]);
  assign adv      = sec_tick && run && !freeze;

  assign wr_time = wr_en && hit_time;
  assign wr_a    = wr_en && (addr == ADDR_W'(A_CTLA));
  assign wr_b    = wr_en && (addr == ADDR_W'(A_CTLB));
  assign rd_a    = rd_en && (addr == ADDR_W'(A_CTLA));
  assign rd_c    = rd_en && (addr == ADDR_W'(A_FLAG));
  assign wr_val  = bin_mode ? wdata : bcd_to_bin(wdata);

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .wr_en    (wr_time),
    .wr_field (fsel),
    .wr_val   (wr_val),
    .tm       (tm)
  );

  rtc_periodic #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .run      (run),
    .restart  (wr_a),
    .rate     (ctla[3:0]),
    .evt      (pevt)
  );

  function automatic logic [7:0] show(input logic [7:0] v, input logic bm);
    return bm ? v : bin_to_bcd(v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip  <= 1'b0;
      ctla <= {DIV_32K, RATE_1K};
      ctlb <= {1'b0, 1'b1, 3'b000, strap_binary, 1'b1, 1'b0};
      pf   <= 1'b0;
      irqf <= 1'b0;
    end else begin
      if (rd_a) uip <= !uip;
      if (wr_a) ctla <= wdata[6:0];
      if (wr_b) ctlb <= wdata;
      if (rd_c) begin
        pf   <= 1'b0;
        irqf <= 1'b0;
      end
      if (pevt) begin
        pf <= 1'b1;
        if (pie) irqf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      if (hit_time) begin
        case (fsel)
          FLD_SEC:  rdata <= show(tm.sec,  bin_mode);
          FLD_MIN:  rdata <= show(tm.min,  bin_mode);
          FLD_HR:   rdata <= show(tm.hr,   bin_mode);
          FLD_WDAY: rdata <= show(tm.wday, bin_mode);
          FLD_MDAY: rdata <= show(tm.mday, bin_mode);
          FLD_MON:  rdata <= show(tm.mon,  bin_mode);
          default:  rdata <= show(tm.yr,   bin_mode);
        endcase
      end else if (addr == ADDR_W'(A_CTLA)) rdata <= {!uip, ctla};
      else if (addr == ADDR_W'(A_CTLB))     rdata <= ctlb;
      else if (addr == ADDR_W'(A_FLAG))     rdata <= {irqf, pf, 6'b0};
      else if (addr == ADDR_W'(A_VALID))    rdata <= 8'h80;
      else                                  rdata <= 8'h00;
    end
  end

  assign irq = irqf;

  assert_uip_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a |=> $stable(uip));

  assert_uip_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a |=> (uip != $past(uip)));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !pevt) |=> !irq);

  assert_irq_needs_pie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(pevt && pie)) |=> !irq);

  assert_valid_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(A_VALID)) |=> (rdata == 8'h80));

  assert_frozen_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_time) |=> $stable(tm));

endmodule

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  import rtc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_binary = 1'b0;
  logic       sec_tick = 1'b0;
  logic       osc_tick = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_regfile uut (
    .clk(clk), .rst_n(rst_n), .strap_binary(strap_binary),
    .sec_tick(sec_tick), .osc_tick(osc_tick), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic sec_pulse();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic osc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, $sformatf("addr %02h", a), v, exp);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h); wr(A_WDAY, wd);
    wr(A_MDAY, md); wr(A_MON, mo); wr(A_YR, y);
  endtask

  task automatic t_reset();
    rd_check("R1", A_CTLB, 8'h42);
    rd_check("R1", A_SEC, 8'h00);
    rd_check("R1", A_MIN, 8'h00);
    rd_check("R1", A_HR, 8'h00);
    rd_check("R1", A_WDAY, 8'h01);
    rd_check("R1", A_MDAY, 8'h01);
    rd_check("R1", A_MON, 8'h01);
    rd_check("R1", A_YR, 8'h00);
    rd_check("R1", A_CTLA, 8'hA6);
    rd_check("R7", A_CTLA, 8'h26);
    rd_check("R11", A_VALID, 8'h80);
    rd_check("R2", 8'h05, 8'h00);
    rd_check("R2", 8'h0E, 8'h00);
    check("R1", "irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_bcd_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    rd_check("R2", A_HR, 8'h23);
    rd_check("R2", A_MDAY, 8'h31);
    sec_pulse();
    rd_check("R4", A_SEC, 8'h00);
    rd_check("R4", A_MIN, 8'h00);
    rd_check("R4", A_HR, 8'h00);
    rd_check("R4", A_WDAY, 8'h01);
    rd_check("R4", A_MDAY, 8'h01);
    rd_check("R4", A_MON, 8'h01);
    rd_check("R4", A_YR, 8'h00);
    set_time(8'h15, 8'h59, 8'h09, 8'h03, 8'h10, 8'h05, 8'h40);
    sec_pulse();
    rd_check("R4", A_SEC, 8'h16);
    rd_check("R4", A_MIN, 8'h59);
  endtask

  task automatic t_month_lengths();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    sec_pulse();
    rd_check("R4", A_MDAY, 8'h29);
    rd_check("R4", A_MON, 8'h02);
    rd_check("R4", A_WDAY, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    sec_pulse();
    rd_check("R4", A_MDAY, 8'h01);
    rd_check("R4", A_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23);
    sec_pulse();
    rd_check("R4", A_MDAY, 8'h01);
    rd_check("R4", A_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
    sec_pulse();
    rd_check("R4", A_MDAY, 8'h01);
    rd_check("R4", A_MON, 8'h05);
    rd_check("R4", A_YR, 8'h23);
  endtask

  task automatic t_binary_mode();
    wr(A_CTLB, 8'h46);
    rd_check("R3", A_CTLB, 8'h46);
    wr(A_SEC, 8'h2D);
    rd_check("R3", A_SEC, 8'h2D);
    sec_pulse();
    rd_check("R3", A_SEC, 8'h2E);
    wr(A_CTLB, 8'h42);
    rd_check("R3", A_SEC, 8'h46);
  endtask

  task automatic t_freeze();
    wr(A_CTLB, 8'hC2);
    sec_pulse();
    sec_pulse();
    rd_check("R5", A_SEC, 8'h46);
    wr(A_CTLB, 8'h42);
    sec_pulse();
    rd_check("R5", A_SEC, 8'h47);
  endtask

  task automatic t_uip();
    logic [7:0] r1, r2, r3;
    rd(A_CTLA, r1);
    wr(A_CTLA, 8'h26);
    rd(A_CTLA, r2);
    check("R6", "bit7 after write of 0", {7'b0, r2[7]}, {7'b0, ~r1[7]});
    check("R6", "low bits", {1'b0, r2[6:0]}, 8'h26);
    wr(A_CTLA, 8'hA6);
    rd(A_CTLA, r3);
    check("R7", "bit7 after write of 1", {7'b0, r3[7]}, {7'b0, ~r2[7]});
  endtask

  task automatic t_periodic();
    wr(A_CTLA, 8'h26);
    rd_check("R9", A_FLAG, 8'h00);
    osc_pulses(31);
    rd_check("R8", A_FLAG, 8'h00);
    osc_pulses(1);
    check("R8", "irq raised", {7'b0, irq}, 8'h01);
    rd_check("R8", A_FLAG, 8'hC0);
    check("R9", "irq dropped", {7'b0, irq}, 8'h00);
    rd_check("R9", A_FLAG, 8'h00);
    wr(A_CTLA, 8'h23);
    osc_pulses(3);
    rd_check("R8", A_FLAG, 8'h00);
    osc_pulses(1);
    rd_check("R8", A_FLAG, 8'hC0);
    wr(A_CTLB, 8'h02);
    wr(A_CTLA, 8'h23);
    osc_pulses(4);
    check("R8", "irq without enable", {7'b0, irq}, 8'h00);
    rd_check("R8", A_FLAG, 8'h40);
    wr(A_CTLB, 8'h42);
    wr(A_FLAG, 8'hFF);
    rd_check("R9", A_FLAG, 8'h00);
    wr(A_VALID, 8'h00);
    rd_check("R11", A_VALID, 8'h80);
  endtask

  task automatic t_divider_stop();
    wr(A_CTLA, 8'h66);
    sec_pulse();
    rd_check("R10", A_SEC, 8'h47);
    osc_pulses(40);
    rd_check("R10", A_FLAG, 8'h00);
    wr(A_CTLA, 8'h76);
    sec_pulse();
    osc_pulses(40);
    rd_check("R10", A_SEC, 8'h47);
    rd_check("R10", A_FLAG, 8'h00);
    wr(A_CTLA, 8'h26);
    sec_pulse();
    rd_check("R10", A_SEC, 8'h48);
  endtask

  task automatic t_strap();
    @(negedge clk);
    rst_n = 1'b0; strap_binary = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_check("R1", A_CTLB, 8'h46);
    rd_check("R1", A_MDAY, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bcd_rollover();
    t_month_lengths();
    t_binary_mode();
    t_freeze();
    t_uip();
    t_periodic();
    t_divider_stop();
    t_strap();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule